// File: doc/BRIEF.md
# Gray-Coded Counter Clock Crossing

This block moves a counter value, for example a running chirp or frame count, from one clock domain into another clock domain with no fixed phase or frequency relation to the first. In the source domain the binary count is turned into Gray code and captured in a register. Between any two neighbouring counts only one bit of the transferred code then changes. In the destination domain the code passes through a chain of synchroniser flops. After the last stage it is decoded back to binary and registered once more, and that register drives the output.

Each side has its own reset input. Each reset is asserted asynchronously and released through a short synchroniser clocked by its own domain. Every flop on the source side is cleared only by the source reset. The synchroniser chain and the output register are cleared only by the destination reset. Either side can be reset on its own, and the two resets can be released in either order.

The source must advance the count by at most one per source clock. Between steps it must leave enough time for the destination to sample each code.

Top module: `gray_count_xing`

## Requirements
- R1: The Gray code is held in a register clocked by `src_clk`, so a new input value reaches the crossing one source cycle later. A change at `src_count` is never visible on `dst_count` within one destination cycle.
- R2: Holding `src_rst_n` low clears only the source register. While the destination keeps running, `dst_count` settles to 0. After release it settles to the value on `src_count`.
- R3: When the input steps by one, modulo 2^WIDTH, exactly one bit of the transferred code changes. This includes the wrap from all ones to zero.
- R4: The destination chain is SYNC_STAGES flops deep and never fewer than two. A value is decoded and registered after the last stage, so a new count does not reach `dst_count` within two destination cycles.
- R5: While `dst_rst_n` is low, `dst_count` is 0. After the destination reset is released, the output stays 0 until the chain has refilled, which takes SYNC_STAGES+1 destination cycles.
- R6: The destination can be reset on its own while the source keeps counting. Once that reset is released, `dst_count` is no more than two counts behind the live source value, and it equals that value once the source stops.
- R7: A source value held steady appears unchanged on `dst_count`. This holds for every value in the range 0 to 2^WIDTH-1.
- R8: While the source steps by one at a time, `dst_count` either holds or advances by exactly one, modulo 2^WIDTH, from one destination cycle to the next.
- R9: Once its reset is released, `dst_count` never carries an X or Z bit.
- R10: The two resets can be released in either order, and in each case the output recovers to the source value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous assertion |
| src_count | input | WIDTH | Binary counter value in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous assertion |
| dst_count | output | WIDTH | Binary counter value recovered in the destination domain |

## Verification
The bench sweeps a 4-bit counter through every value and past its wrap, with a 3-stage chain and unrelated clock periods. If the Gray encoding or decoding were wrong, held values would read back wrongly and the output would skip counts. If the source reset were wired into the destination side, or the reverse, the tests that reset one side alone would show a stuck zero or stale data. The bench also releases the resets in both orders and resets the destination while the source is still counting. These cases catch a design that latches garbage or fails to refill its chain. Early samples taken right after a step catch a chain that is too short or a source stage that is combinational.

// File: rtl/gxc_pkg.sv
package gxc_pkg;
    // Minimum depth the destination chain is ever allowed to have.
    localparam int unsigned GXC_MIN_SYNC = 2;
    // Depth of each reset release synchroniser.
    localparam int unsigned GXC_RST_STAGES = 2;

    // Width of a counter that must reach n+1.
    function automatic int unsigned gxc_cnt_bits(input int unsigned n);
        return $clog2(n + 2);
    endfunction
endpackage

// File: rtl/gxc_rst_sync.sv
module gxc_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign rst_n_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gxc_src_stage.sv
module gxc_src_stage #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bin_i,
    output logic [WIDTH-1:0] gray_o
);
    typedef struct packed {
        logic [WIDTH-1:0] gray;
        logic             warm;
    } src_st_t;

    src_st_t st_d, st_q;
    logic [WIDTH-1:0] held_bin;   // decode of the registered code

    always_comb begin
        st_d.gray = bin_i ^ (bin_i >> 1);
        st_d.warm = 1'b1;
        held_bin[WIDTH-1] = st_q.gray[WIDTH-1];
        for (int i = WIDTH - 2; i >= 0; i--) begin
            held_bin[i] = held_bin[i+1] ^ st_q.gray[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gray_o = st_q.gray;

    // R1: registered code carries the input of the previous source cycle
    a_r1_gray_registered: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.warm |-> (held_bin == $past(bin_i)));

    // R3: a unit step of the input flips at most one code bit
    a_r3_single_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((bin_i == held_bin) || (bin_i == held_bin + WIDTH'(1)))
        |-> $onehot0(st_d.gray ^ st_q.gray));
endmodule

// File: rtl/gxc_sync_chain.sv
module gxc_sync_chain #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_comb stage_d[g] = d_i;
        end else begin : g_tail
            always_comb stage_d[g] = stage_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gxc_dst_stage.sv
module gxc_dst_stage
    import gxc_pkg::*;
#(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] gray_i,
    output logic [WIDTH-1:0] bin_o
);
    localparam int unsigned WARM_W   = gxc_cnt_bits(STAGES);
    localparam int unsigned WARM_TOP = STAGES + 1;

    typedef struct packed {
        logic [WIDTH-1:0]  bin;
        logic [WARM_W-1:0] warm;
    } dst_st_t;

    dst_st_t st_d, st_q;

    always_comb begin
        st_d.bin[WIDTH-1] = gray_i[WIDTH-1];
        for (int i = WIDTH - 2; i >= 0; i--) begin
            st_d.bin[i] = st_d.bin[i+1] ^ gray_i[i];
        end
        st_d.warm = (st_q.warm == WARM_W'(WARM_TOP)) ? st_q.warm
                                                     : st_q.warm + WARM_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bin_o = st_q.bin;

    // R5: output held at zero while the chain refills after reset
    a_r5_refill_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm <= WARM_W'(STAGES)) |-> (bin_o == '0));

    // R9: no unknown bits on the output out of reset
    a_r9_output_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(bin_o));
endmodule

// File: rtl/gray_count_xing.sv
module gray_count_xing
    import gxc_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic [WIDTH-1:0] src_count,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic [WIDTH-1:0] dst_count
);
    localparam int unsigned CHAIN = (SYNC_STAGES < GXC_MIN_SYNC) ? GXC_MIN_SYNC
                                                                 : SYNC_STAGES;

    logic             src_rst_sync_n;
    logic             dst_rst_sync_n;
    logic [WIDTH-1:0] src_gray;
    logic [WIDTH-1:0] dst_gray;

    gxc_rst_sync #(.STAGES(GXC_RST_STAGES)) u_src_rst (
        .clk     (src_clk),
        .arst_n  (src_rst_n),
        .rst_n_o (src_rst_sync_n)
    );

    gxc_rst_sync #(.STAGES(GXC_RST_STAGES)) u_dst_rst (
        .clk     (dst_clk),
        .arst_n  (dst_rst_n),
        .rst_n_o (dst_rst_sync_n)
    );

    gxc_src_stage #(.WIDTH(WIDTH)) u_src (
        .clk    (src_clk),
        .rst_n  (src_rst_sync_n),
        .bin_i  (src_count),
        .gray_o (src_gray)
    );

    gxc_sync_chain #(.WIDTH(WIDTH), .STAGES(CHAIN)) u_chain (
        .clk   (dst_clk),
        .rst_n (dst_rst_sync_n),
        .d_i   (src_gray),
        .q_o   (dst_gray)
    );

    gxc_dst_stage #(.WIDTH(WIDTH), .STAGES(CHAIN)) u_dst (
        .clk    (dst_clk),
        .rst_n  (dst_rst_sync_n),
        .gray_i (dst_gray),
        .bin_o  (dst_count)
    );
endmodule

// File: tb/sim_gray_count_xing.sv
`timescale 1ns/1ps
module sim_gray_count_xing;
    localparam int unsigned W  = 4;
    localparam int unsigned NS = 3;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst_n = 1'b1;
    logic         dst_rst_n = 1'b1;
    logic [W-1:0] src_count = '0;
    logic [W-1:0] dst_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit           mon_en    = 1'b0;
    bit           mon_armed = 1'b0;
    logic [W-1:0] mon_prev  = '0;

    always #2.5 src_clk = ~src_clk;   // 200 MHz
    always #3.5 dst_clk = ~dst_clk;   // unrelated destination clock

    gray_count_xing #(.WIDTH(W), .SYNC_STAGES(NS)) u0 (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_count (src_count),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_count (dst_count)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: dst_count=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic dst_wait(input int n);
        repeat (n) @(negedge dst_clk);
    endtask

    task automatic src_step();
        @(negedge src_clk);
        src_count = src_count + W'(1);
    endtask

    // R8: output holds or advances by one between destination cycles
    always @(negedge dst_clk) begin
        if (mon_en) begin
            if (mon_armed) begin
                checks++;
                if (!(dst_count == mon_prev || dst_count == mon_prev + W'(1))) begin
                    fails++;
                    $display("FAIL R8: dst_count=%0d expected %0d or %0d", dst_count,
                             mon_prev, mon_prev + W'(1));
                end
            end
            mon_prev  = dst_count;
            mon_armed = 1'b1;
        end else begin
            mon_armed = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge src_clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #1;
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        #20;
        check("R5 in reset", dst_count, '0);
        checks++;
        if ($isunknown(dst_count)) begin
            fails++;
            $display("FAIL R9: dst_count=%b expected known", dst_count);
        end

        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        dst_wait(12);
        check("R9 after reset", dst_count, '0);

        // Sweep every value and across the wrap
        mon_en = 1'b1;
        for (int i = 1; i <= 19; i++) begin
            src_step();
            dst_wait(1);
            check("R1 not yet visible", dst_count, W'(i - 1));
            dst_wait(1);
            check("R4 chain latency", dst_count, W'(i - 1));
            dst_wait(10);
            if ((i % (1 << W)) == 0) check("R3 wrap to zero", dst_count, W'(i));
            else                     check("R7 held value", dst_count, W'(i));
        end
        mon_en = 1'b0;
        dst_wait(2);

        // Source-only reset (value 3 at input)
        @(negedge src_clk);
        src_rst_n = 1'b0;
        dst_wait(12);
        check("R2 source reset clears", dst_count, '0);
        @(negedge src_clk);
        src_rst_n = 1'b1;
        dst_wait(12);
        check("R2 source recovers", dst_count, W'(3));

        // Staggered release: destination first
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        src_count = W'(7);
        dst_wait(3);
        dst_rst_n = 1'b1;
        dst_wait(10);
        check("R10 dst first, src held", dst_count, '0);
        src_rst_n = 1'b1;
        dst_wait(12);
        check("R10 dst first recovers", dst_count, W'(7));

        // Staggered release: source first
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        src_count = W'(11);
        dst_wait(3);
        src_rst_n = 1'b1;
        dst_wait(10);
        check("R5 dst still in reset", dst_count, '0);
        dst_rst_n = 1'b1;
        dst_wait(12);
        check("R10 src first recovers", dst_count, W'(11));

        // Destination-only reset while the source keeps counting
        fork
            begin
                for (int k = 0; k < 12; k++) begin
                    src_step();
                    repeat (3) @(negedge src_clk);
                end
            end
            begin
                dst_wait(4);
                dst_rst_n = 1'b0;
                dst_wait(1);
                check("R5 dst-only reset", dst_count, '0);
                dst_wait(2);
                dst_rst_n = 1'b1;
                dst_wait(10);
                checks++;
                if (W'(src_count - dst_count) > W'(2)) begin
                    fails++;
                    $display("FAIL R6: dst_count=%0d expected within 2 of %0d",
                             dst_count, src_count);
                end
            end
        join
        dst_wait(12);
        check("R6 converged", dst_count, W'(11 + 12));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule